// File: doc/BRIEF.md
# Multi-row sketch counter updater

This block keeps a count-style sketch of a traffic stream. Each incoming record carries a 32-bit flow key, the source IPv4 address of a frame, and an update amount, the frame length. A small queue absorbs the records so that hashing and the memory pipeline never stall frame intake. For every record the block adds the amount to one counter in each of `ROWS` independent rows. The counter chosen in each row comes from that row's own hash of the key.

The counters are held in two complete sketch banks. One bank, the active one, absorbs updates during the current observation interval. The other bank holds the finished interval and is readable by the host. A single-cycle epoch pulse swaps the two roles. When the host has finished reading the retired bank, it pulses `host_done`. The block then zeroes that bank so that it starts empty the next time it becomes active.

After reset the block zeroes both banks before it applies any record. The deployment sizing is three rows of 4096 counters (`IDX_W` = 12). The default parameters are smaller so that the model stays light, and every size is a parameter.

Top module: `sketch_updater`

## Requirements
- R1: During reset and on the first cycle after it, `ovf_pulse` and `host_rd_valid` are low and bank 0 is active. For the first K = 2^IDX_W cycles after reset is released, the block zeroes every counter of both banks. Records queued during that time are held and applied afterwards.
- R2: Each accepted record adds `in_len` to exactly one counter per row r. The index is the upper IDX_W bits of (key × M_r) mod 2^KEY_W, where M_r = (0x9E3779B1 + r × 0x85EBCA6A) mod 2^32 with bit 0 forced to 1.
- R3: Counters are CNT_W bits wide and wrap modulo 2^CNT_W.
- R4: Records that arrive back to back and hit the same counter all accumulate, with no increment lost.
- R5: The queue holds up to FIFO_DEPTH records. A record offered while FIFO_DEPTH records are held is dropped. In that case `ovf_pulse` is high for one cycle, the cycle after the offer.
- R6: An `epoch` pulse toggles the active bank. Records applied afterwards go to the new active bank, and host reads address the other bank.
- R7: For a `host_rd_en` request, the counter at `host_rd_row`/`host_rd_idx` of the inactive bank appears on `host_rd_data`, with `host_rd_valid` high, exactly two cycles later.
- R8: A `host_done` pulse zeroes every counter of the bank that is inactive at that moment within K cycles. The active bank is left untouched.
- R9: Outside the post-reset clearing, the queue drains one record per clock. A stream of one record per clock therefore never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Record offered this cycle |
| in_key | input | KEY_W | Flow key (source address) |
| in_len | input | LEN_W | Update amount (frame length) |
| epoch | input | 1 | Observation interval boundary, swaps banks |
| host_done | input | 1 | Host finished reading the inactive bank; clear it |
| host_rd_en | input | 1 | Host read request |
| host_rd_row | input | ROW_W | Row to read |
| host_rd_idx | input | IDX_W | Counter index to read |
| host_rd_valid | output | 1 | Read data valid |
| host_rd_data | output | CNT_W | Counter value read |
| ovf_pulse | output | 1 | A record was dropped on a full queue |

## Verification
The bench builds the block with IDX_W = 4 (16 counters per row) and a queue depth of 4. These small sizes make hash collisions between different keys frequent, keep each full-bank sweep and clear down to a few dozen cycles, and let a short burst during the post-reset clearing reach overflow. It sets LEN_W to 32, so that two large updates bring a counter across the 2^32 wrap. Every counter of a retired bank is read back after each interval and compared with a behavioural model. That model accumulates, swaps and clears banks independently of the RTL.

// File: rtl/sketch_pkg.sv
package sketch_pkg;

  localparam logic [31:0] MULT_BASE = 32'h9E3779B1;
  localparam logic [31:0] MULT_STEP = 32'h85EBCA6A;

  // Odd multiplier of the multiplicative hash for one row.
  function automatic logic [31:0] row_mult(input int unsigned row);
    return (MULT_BASE + MULT_STEP * 32'(row)) | 32'h1;
  endfunction

endpackage

// File: rtl/sketch_hash.sv
module sketch_hash #(
  parameter int KEY_W = 32,
  parameter int IDX_W = 8,
  parameter int ROWS  = 3
) (
  input  logic [KEY_W-1:0]      key,
  output logic [ROWS*IDX_W-1:0] idx
);
  localparam int SHIFT = KEY_W - IDX_W;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [KEY_W-1:0] prod;
    assign prod = key * KEY_W'(sketch_pkg::row_mult(r));
    assign idx[r*IDX_W +: IDX_W] = IDX_W'(prod >> SHIFT);
  end
endmodule

// File: rtl/sketch_fifo.sv
module sketch_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          acc, take;

  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign acc   = push && !full;
  assign take  = pop && !empty;
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (acc) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (acc)  wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (take) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(acc) - (AW+1)'(take);
    end
  end
endmodule

// File: rtl/sketch_ram.sv
module sketch_ram #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] rb,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [1<<AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[ra];
    rdata_b <= mem[rb];
  end
endmodule

// File: rtl/sketch_updater.sv
module sketch_updater #(
  parameter int KEY_W      = 32,
  parameter int LEN_W      = 16,
  parameter int CNT_W      = 32,
  parameter int ROWS       = 3,
  parameter int IDX_W      = 8,
  parameter int FIFO_DEPTH = 8,
  localparam int ROW_W     = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [KEY_W-1:0] in_key,
  input  logic [LEN_W-1:0] in_len,
  input  logic             epoch,
  input  logic             host_done,
  input  logic             host_rd_en,
  input  logic [ROW_W-1:0] host_rd_row,
  input  logic [IDX_W-1:0] host_rd_idx,
  output logic             host_rd_valid,
  output logic [CNT_W-1:0] host_rd_data,
  output logic             ovf_pulse
);
  localparam int K    = 1 << IDX_W;
  localparam int REC_W = KEY_W + LEN_W;

  logic act_bank;

  // Clear sequencer: both banks after reset, retired bank on host_done.
  logic             clr_run, clr_all, clr_bank;
  logic [IDX_W-1:0] clr_idx;
  logic             init_hold;

  // Record queue.
  logic             q_empty, q_full, q_pop;
  logic [REC_W-1:0] q_dout;

  // Pipeline stages: s0 hashes and issues reads, s1 adds and writes.
  logic                  s0_v, s0_bank, s1_v, s1_bank;
  logic [KEY_W-1:0]      s0_key;
  logic [LEN_W-1:0]      s0_len, s1_len;
  logic [ROWS*IDX_W-1:0] s0_idx, s1_idx, w_idx;
  logic [ROWS*CNT_W-1:0] s1_sum, w_data;
  logic                  w_v, w_bank;
  logic [CNT_W-1:0]      fwd_base;

  logic [ROWS*2*CNT_W-1:0] rd_upd, rd_host;

  logic             hr_v1, hr_bank1;
  logic [ROW_W-1:0] hr_row1;
  logic [CNT_W-1:0] hr_sel;

  assign init_hold = clr_run && clr_all;
  assign q_pop     = !q_empty && !init_hold;

  always_ff @(posedge clk) begin
    if (rst) act_bank <= 1'b0;
    else if (epoch) act_bank <= ~act_bank;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_run  <= 1'b1;
      clr_all  <= 1'b1;
      clr_bank <= 1'b0;
      clr_idx  <= '0;
    end else if (clr_run) begin
      clr_idx <= clr_idx + 1'b1;
      if (clr_idx == IDX_W'(K-1)) begin
        clr_run <= 1'b0;
        clr_all <= 1'b0;
      end
    end else if (host_done) begin
      clr_run  <= 1'b1;
      clr_bank <= ~act_bank;
      clr_idx  <= '0;
    end
  end

  sketch_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(in_valid), .din({in_key, in_len}),
    .pop(q_pop), .dout(q_dout), .empty(q_empty), .full(q_full)
  );

  always_ff @(posedge clk) begin
    if (rst) ovf_pulse <= 1'b0;
    else     ovf_pulse <= in_valid && q_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s0_v <= 1'b0;
      s1_v <= 1'b0;
      w_v  <= 1'b0;
    end else begin
      s0_v <= q_pop;
      s1_v <= s0_v;
      w_v  <= s1_v;
    end
    s0_key  <= q_dout[REC_W-1 -: KEY_W];
    s0_len  <= q_dout[LEN_W-1:0];
    s0_bank <= act_bank;
    s1_idx  <= s0_idx;
    s1_len  <= s0_len;
    s1_bank <= s0_bank;
    w_idx   <= s1_idx;
    w_data  <= s1_sum;
    w_bank  <= s1_bank;
  end

  sketch_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W), .ROWS(ROWS)) u_hash (
    .key(s0_key), .idx(s0_idx)
  );

  // Add with forwarding of the write made one cycle earlier.
  always_comb begin
    s1_sum   = '0;
    fwd_base = '0;
    for (int r = 0; r < ROWS; r++) begin
      fwd_base = s1_bank ? rd_upd[(r*2+1)*CNT_W +: CNT_W]
                         : rd_upd[(r*2)*CNT_W +: CNT_W];
      if (w_v && (w_bank == s1_bank) &&
          (w_idx[r*IDX_W +: IDX_W] == s1_idx[r*IDX_W +: IDX_W]))
        fwd_base = w_data[r*CNT_W +: CNT_W];
      s1_sum[r*CNT_W +: CNT_W] = fwd_base + CNT_W'(s1_len);
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar b = 0; b < 2; b++) begin : g_bank
      logic             clr_hit, upd_hit, we;
      logic [IDX_W-1:0] wa;
      logic [CNT_W-1:0] wd;
      assign clr_hit = clr_run && (clr_all || (clr_bank == 1'(b)));
      assign upd_hit = s1_v && (s1_bank == 1'(b));
      assign we      = clr_hit || upd_hit;
      assign wa      = clr_hit ? clr_idx : s1_idx[r*IDX_W +: IDX_W];
      assign wd      = clr_hit ? '0 : s1_sum[r*CNT_W +: CNT_W];

      sketch_ram #(.DW(CNT_W), .AW(IDX_W)) u_ram (
        .clk(clk), .we(we), .waddr(wa), .wdata(wd),
        .ra(s0_idx[r*IDX_W +: IDX_W]),
        .rdata_a(rd_upd[(r*2+b)*CNT_W +: CNT_W]),
        .rb(host_rd_idx),
        .rdata_b(rd_host[(r*2+b)*CNT_W +: CNT_W])
      );
    end
  end

  // Host read: RAM register, then row/bank select register.
  always_comb begin
    hr_sel = '0;
    for (int r = 0; r < ROWS; r++)
      for (int b = 0; b < 2; b++)
        if (hr_row1 == ROW_W'(r) && hr_bank1 == 1'(b))
          hr_sel = rd_host[(r*2+b)*CNT_W +: CNT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hr_v1         <= 1'b0;
      host_rd_valid <= 1'b0;
      host_rd_data  <= '0;
    end else begin
      hr_v1         <= host_rd_en;
      host_rd_valid <= hr_v1;
      host_rd_data  <= hr_v1 ? hr_sel : '0;
    end
    hr_row1  <= host_rd_row;
    hr_bank1 <= ~act_bank;
  end
endmodule

// File: rtl/sketch_updater_chk.sv
module sketch_updater_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic ovf_pulse,
  input logic epoch,
  input logic act_bank,
  input logic host_done,
  input logic clr_run,
  input logic host_rd_en,
  input logic host_rd_valid
);
  a_r5_drop_needs_offer: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> $past(in_valid));

  a_r6_epoch_swaps_bank: assert property (@(posedge clk) disable iff (rst)
    epoch |=> (act_bank != $past(act_bank)));

  a_r7_read_returns: assert property (@(posedge clk) disable iff (rst)
    host_rd_en |-> ##2 host_rd_valid);

  a_r7_no_stray_valid: assert property (@(posedge clk) disable iff (rst)
    host_rd_valid |-> $past(host_rd_en, 2));

  a_r8_clear_starts: assert property (@(posedge clk) disable iff (rst)
    (host_done && !clr_run) |=> clr_run);
endmodule

bind sketch_updater sketch_updater_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .ovf_pulse(ovf_pulse),
  .epoch(epoch), .act_bank(act_bank), .host_done(host_done),
  .clr_run(clr_run), .host_rd_en(host_rd_en), .host_rd_valid(host_rd_valid)
);

// File: tb/sim_sketch_updater.sv
module sim_sketch_updater;
  localparam int KEY_W = 32, LEN_W = 32, CNT_W = 32, ROWS = 3;
  localparam int IDX_W = 4, DEPTH = 4, K = 1 << IDX_W, ROW_W = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, epoch = 1'b0, host_done = 1'b0, host_rd_en = 1'b0;
  logic [KEY_W-1:0] in_key = '0;
  logic [LEN_W-1:0] in_len = '0;
  logic [ROW_W-1:0] host_rd_row = '0;
  logic [IDX_W-1:0] host_rd_idx = '0;
  logic             host_rd_valid, ovf_pulse;
  logic [CNT_W-1:0] host_rd_data;

  always #2 clk = ~clk;

  sketch_updater #(.KEY_W(KEY_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .ROWS(ROWS),
                   .IDX_W(IDX_W), .FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_key(in_key), .in_len(in_len),
    .epoch(epoch), .host_done(host_done), .host_rd_en(host_rd_en),
    .host_rd_row(host_rd_row), .host_rd_idx(host_rd_idx),
    .host_rd_valid(host_rd_valid), .host_rd_data(host_rd_data), .ovf_pulse(ovf_pulse)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  // Behavioural reference model.
  logic [31:0] mdl [2][ROWS][K];
  bit          mbank, exp_ovf, p1_v, exp_v;
  logic [31:0] p1_d, exp_d;
  int          mcnt, edges;

  function automatic logic [IDX_W-1:0] hsh(int r, logic [31:0] k);
    logic [31:0] m, p;
    m = (32'h9E3779B1 + 32'h85EBCA6A * r) | 32'h1;
    p = k * m;
    return p[31 -: IDX_W];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mbank = 0; mcnt = 0; edges = 0; exp_ovf = 0; p1_v = 0; exp_v = 0;
      p1_d = '0; exp_d = '0;
      for (int b = 0; b < 2; b++)
        for (int r = 0; r < ROWS; r++)
          for (int i = 0; i < K; i++) mdl[b][r][i] = '0;
    end else begin
      bit pop;
      edges++;
      exp_v = p1_v; exp_d = p1_d;
      p1_v = host_rd_en;
      if (host_rd_en) p1_d = mdl[!mbank][host_rd_row][host_rd_idx];
      pop = (mcnt > 0) && (edges > K);
      exp_ovf = in_valid && (mcnt == DEPTH);
      if (in_valid && mcnt < DEPTH) begin
        for (int r = 0; r < ROWS; r++)
          mdl[mbank][r][hsh(r, in_key)] = mdl[mbank][r][hsh(r, in_key)] + in_len;
        mcnt++;
      end
      if (pop) mcnt--;
      if (host_done)
        for (int r = 0; r < ROWS; r++)
          for (int i = 0; i < K; i++) mdl[!mbank][r][i] = '0;
      if (epoch) mbank = !mbank;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare outputs against the model on every clock.
  always @(negedge clk) begin
    if (!finished) begin
      if (rst) begin
        chk(ovf_pulse == 1'b0, "R1 ovf in reset", 32'(ovf_pulse), 0);
        chk(host_rd_valid == 1'b0, "R1 valid in reset", 32'(host_rd_valid), 0);
      end else begin
        chk(ovf_pulse == exp_ovf, "R5 overflow flag", 32'(ovf_pulse), 32'(exp_ovf));
        chk(host_rd_valid == exp_v, "R7 read valid", 32'(host_rd_valid), 32'(exp_v));
        if (exp_v) chk(host_rd_data == exp_d, cur_req, host_rd_data, exp_d);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 0; epoch = 0; host_done = 0; host_rd_en = 0;
    end
  endtask

  task automatic push(logic [31:0] k, logic [31:0] l);
    @(negedge clk);
    in_valid = 1; in_key = k; in_len = l;
    epoch = 0; host_done = 0; host_rd_en = 0;
  endtask

  task automatic pulse_epoch();
    @(negedge clk);
    in_valid = 0; epoch = 1;
    idle(1);
  endtask

  task automatic read_bank();
    for (int r = 0; r < ROWS; r++)
      for (int i = 0; i < K; i++) begin
        @(negedge clk);
        in_valid = 0; epoch = 0; host_done = 0;
        host_rd_en = 1; host_rd_row = ROW_W'(r); host_rd_idx = IDX_W'(i);
      end
    idle(4);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R5: burst during post-reset clearing fills the queue and overflows.
    cur_req = "R5";
    for (int n = 0; n < DEPTH + 2; n++) push(32'hC0A80001 + n * 32'h01010101, 32'd100 + n);
    idle(K + 12);
    // R1 + R2: counters of the filled bank match the model, others zero.
    pulse_epoch();
    cur_req = "R2 first interval contents";
    read_bank();
    // R4 + R9: back-to-back same key, alternating keys, full-rate stream.
    cur_req = "R4";
    for (int n = 0; n < 5; n++) push(32'h0A000001, 32'd64);
    for (int n = 0; n < 4; n++) push((n % 2) ? 32'h0B0B0B0B : 32'h0A000001, 32'd1500);
    cur_req = "R9";
    for (int n = 0; n < 10; n++) push(32'h17000000 + n * 32'h00130007, 32'(n * 7 + 40));
    // R3: counter wraps.
    push(32'hDEADBEEF, 32'hFFFFFFF0);
    push(32'hDEADBEEF, 32'h00000025);
    idle(10);
    pulse_epoch();
    cur_req = "R4 R3 R9 R6 second interval contents";
    read_bank();
    // R8: clear the retired bank while the active bank keeps data.
    push(32'h55AA55AA, 32'd9);
    idle(6);
    @(negedge clk);
    host_done = 1;
    idle(K + 4);
    cur_req = "R8 cleared bank";
    read_bank();
    pulse_epoch();
    cur_req = "R8 R6 active bank kept";
    read_bank();
    idle(4);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule